// File: doc/BRIEF.md
# Lock-qualified processor reset generator

This block drives a shared, active-low processor reset line that doubles as a lock indicator for the clock generator feeding the processor. The line is pulled low whenever an external PLL model reports that it is out of lock, whenever the asynchronous master reset is asserted, and whenever an asynchronous active-low reset request is present. Once every holding cause has gone away, the line stays low for a fixed stretch of output clock cycles, 1024 by default. It is then released to high impedance, and an external pull-up brings it high. A high level on the line therefore means that the clock is locked and no reset is pending.

The request input may come from a push-button or a supervisor and need not be aligned to the clock. An asynchronous-set latch catches even a pulse far shorter than one clock period, and a two-flop synchronizer carries it into the output clock domain. The lock input is synchronized the same way before it restarts the stretch. The block never touches the clock itself, so the processor keeps receiving a running, locked clock during the whole reset window. The line is modelled as an active-high drive-low enable and a tri-state pin that is only ever driven to 0.

Top module: `lock_rst_gen`

## Requirements
- R1: While the master reset `arst_n` is low, `drv_low_o` is 1 and the line `rst_io` reads 0, whatever the other inputs are.
- R2: While `req_n` is low, `drv_low_o` is 1 in the same cycle with no clock edge needed, and it stays 1 for as long as `req_n` stays low.
- R3: Let N be the count of rising clock edges before `req_n` returns high, counting from time zero. With the default stretch of 1024, the line is still low after edge N+1026 and is released after edge N+1027: two synchronizer stages, one restart edge, then 1024 counted cycles.
- R4: A low pulse on `req_n` that begins and ends between two rising edges is captured. It gives the same release timing as R3, taken from the end of the pulse.
- R5: A new request that arrives while a stretch is running restarts the full stretch. The release follows R3 timing from the new request and ignores the earlier one.
- R6: When `lock_i` falls, `drv_low_o` goes to 1 at once, without waiting for a clock edge.
- R7: When `lock_i` rises between edges N and N+1 and no request is pending, the line is still low after edge N+1025 and is released after edge N+1026.
- R8: When released, `drv_low_o` is 0 and the pin is not driven, so the line reads 1 only through the external pull-up. The block never drives the line to 1.
- R9: After `arst_n` rises between edges N and N+1 with `lock_i` high and no request, the release timing is the same as in R7.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Output clock of the PLL; the stretch is counted on its rising edges |
| arst_n | input | 1 | Asynchronous master reset, active low |
| lock_i | input | 1 | Lock indication from the PLL model, 1 = locked |
| req_n | input | 1 | Asynchronous reset request, active low, any pulse width |
| drv_low_o | output | 1 | Drive-low enable of the open-drain line, 1 = pulling low |
| rst_io | inout | 1 | Open-drain reset / lock line; driven 0 or left high impedance |

## Verification
Each result is due at a fixed point in time. Assertion of the line by a request, a lock loss or the master reset is due in the same instant, with no clock edge needed. A request release is due exactly 1027 rising edges after its last low level, and a lock return or master reset release exactly 1026 edges after. The bench numbers every rising edge. Each stimulus is applied one nanosecond after a falling edge and logs the edge count at that moment. From that count it queues the values expected on the falling edge just before the release and on the one just after. A monitor compares the ports on those falling edges, so a stretch one cycle too short or too long is caught, along with any release that is early or missed.

// File: rtl/lrg_pkg.sv
package lrg_pkg;

    // Default length of the reset stretch, in output clock cycles.
    parameter int unsigned LRG_STRETCH_DEFAULT = 1024;

    // Two-stage synchronizer state: first (metastable) and second (settled) flop.
    typedef struct packed {
        logic meta;
        logic settled;
    } lrg_sync_t;

endpackage

// File: rtl/lrg_sync2.sv
module lrg_sync2
    import lrg_pkg::*;
#(
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic arst_n,
    input  logic din,
    output logic meta_o,
    output logic dout
);

    lrg_sync_t sync_d, sync_q;

    always_comb begin
        sync_d.meta    = din;
        sync_d.settled = sync_q.meta;
    end

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) begin
            sync_q <= '{meta: RST_VAL, settled: RST_VAL};
        end else begin
            sync_q <= sync_d;
        end
    end

    assign meta_o = sync_q.meta;
    assign dout   = sync_q.settled;

endmodule

// File: rtl/lrg_req_capture.sv
module lrg_req_capture (
    input  logic clk,
    input  logic arst_n,
    input  logic req_n,
    output logic pend_o,
    output logic req_s_o
);

    // Catch flop: set at once by a low request, cleared by the first clock
    // edge that sees the request high again, so even a very short pulse
    // survives until the synchronizer has sampled it.
    logic catch_q;

    always_ff @(posedge clk or negedge req_n) begin
        if (!req_n) begin
            catch_q <= 1'b1;
        end else begin
            catch_q <= 1'b0;
        end
    end

    logic stage1;

    lrg_sync2 #(.RST_VAL(1'b0)) u_req_sync (
        .clk    (clk),
        .arst_n (arst_n),
        .din    (catch_q),
        .meta_o (stage1),
        .dout   (req_s_o)
    );

    // The request counts as pending while it travels through any stage.
    assign pend_o = catch_q | stage1 | req_s_o;

endmodule

// File: rtl/lrg_stretch.sv
module lrg_stretch #(
    parameter int unsigned CYCLES = 1024
) (
    input  logic clk,
    input  logic arst_n,
    input  logic hold_i,
    output logic busy_o
);

    localparam int unsigned CW = (CYCLES > 2) ? $clog2(CYCLES) : 1;
    localparam logic [CW-1:0] TERM = CW'(CYCLES - 1);

    typedef struct packed {
        logic          busy;
        logic [CW-1:0] cnt;
    } stretch_t;

    stretch_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (hold_i) begin
            st_d.busy = 1'b1;
            st_d.cnt  = '0;
        end else if (st_q.busy) begin
            if (st_q.cnt == TERM) begin
                st_d.busy = 1'b0;
                st_d.cnt  = '0;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) begin
            st_q <= '{busy: 1'b1, cnt: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign busy_o = st_q.busy;

endmodule

// File: rtl/lock_rst_gen.sv
module lock_rst_gen
    import lrg_pkg::*;
#(
    parameter int unsigned CYCLES = LRG_STRETCH_DEFAULT
) (
    input  logic clk,
    input  logic arst_n,
    input  logic lock_i,
    input  logic req_n,
    output logic drv_low_o,
    inout  wire  rst_io
);

    logic req_pend;
    logic req_s;
    logic lock_meta;
    logic lock_s;
    logic busy;
    logic hold;

    lrg_req_capture u_capture (
        .clk     (clk),
        .arst_n  (arst_n),
        .req_n   (req_n),
        .pend_o  (req_pend),
        .req_s_o (req_s)
    );

    lrg_sync2 #(.RST_VAL(1'b0)) u_lock_sync (
        .clk    (clk),
        .arst_n (arst_n),
        .din    (lock_i),
        .meta_o (lock_meta),
        .dout   (lock_s)
    );

    // The stretch restarts while the synchronized request is active or lock is absent.
    assign hold = req_s | ~lock_s;

    lrg_stretch #(.CYCLES(CYCLES)) u_stretch (
        .clk    (clk),
        .arst_n (arst_n),
        .hold_i (hold),
        .busy_o (busy)
    );

    // Direct terms give an immediate low on master reset, lock loss or request.
    assign drv_low_o = ~arst_n | ~lock_i | req_pend | busy | (lock_meta & ~lock_s);

    // Open drain: pull low or float, never drive high.
    assign rst_io = drv_low_o ? 1'b0 : 1'bz;

endmodule

// File: rtl/lrg_checker.sv
module lrg_checker #(
    parameter int unsigned CYCLES = 1024
) (
    input logic clk,
    input logic arst_n,
    input logic lock_i,
    input logic req_n,
    input logic drv_low_o
);

    localparam int unsigned QW = $clog2(CYCLES + 4) + 1;
    localparam logic [QW-1:0] QSAT = QW'(CYCLES + 3);

    // Edges seen in a row with lock present and no request.
    logic [QW-1:0] quiet_q;

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) begin
            quiet_q <= '0;
        end else if (!(lock_i && req_n)) begin
            quiet_q <= '0;
        end else if (quiet_q != QSAT) begin
            quiet_q <= quiet_q + 1'b1;
        end
    end

    // R1: master reset always pulls the line.
    always_comb begin
        if (arst_n == 1'b0) begin
            p_master_low_r1: assert (drv_low_o == 1'b1)
                else $error("R1 line released during master reset");
        end
    end

    p_req_hold_r2: assert property (@(posedge clk) disable iff (!arst_n)
        !req_n |-> drv_low_o)
        else $error("R2 line released while request held");

    p_lock_hold_r6: assert property (@(posedge clk) disable iff (!arst_n)
        !lock_i |-> drv_low_o)
        else $error("R6 line released while unlocked");

    // R3 / R5 / R7: no release before a full quiet stretch.
    p_min_stretch_r3: assert property (@(posedge clk) disable iff (!arst_n)
        !drv_low_o |-> (quiet_q >= QW'(CYCLES)))
        else $error("R3 line released before full stretch");

endmodule

bind lock_rst_gen lrg_checker #(.CYCLES(CYCLES)) u_lrg_checker (
    .clk       (clk),
    .arst_n    (arst_n),
    .lock_i    (lock_i),
    .req_n     (req_n),
    .drv_low_o (drv_low_o)
);

// File: tb/lock_rst_gen_tb.sv
`timescale 1ns/1ps
module lock_rst_gen_tb;

    logic clk = 1'b0;
    logic arst_n = 1'b0;
    logic lock_i = 1'b1;
    logic req_n = 1'b1;
    logic drv_low;
    wire  rst_line;

    pullup (rst_line);

    lock_rst_gen u_dut (
        .clk       (clk),
        .arst_n    (arst_n),
        .lock_i    (lock_i),
        .req_n     (req_n),
        .drv_low_o (drv_low),
        .rst_io    (rst_line)
    );

    always #2.5 clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    typedef struct {
        int    at;
        logic  low;
        string tag;
    } exp_t;

    exp_t sbq[$];

    task automatic chk(input string tag, input logic got_drv, input logic got_line, input logic exp_low);
        checks++;
        if (got_drv !== exp_low || got_line !== ~exp_low) begin
            fails++;
            $display("FAIL %s cyc=%0d drv_low=%b line=%b expected drv_low=%b line=%b",
                     tag, cyc, got_drv, got_line, exp_low, ~exp_low);
        end
    endtask

    // Driver side: queue an expected line state at a given edge count, kept sorted.
    task automatic push_exp(input int at, input logic low, input string tag);
        exp_t it;
        int idx;
        it.at = at; it.low = low; it.tag = tag;
        idx = sbq.size();
        for (int i = 0; i < sbq.size(); i++) begin
            if (sbq[i].at > at) begin
                idx = i;
                break;
            end
        end
        sbq.insert(idx, it);
    endtask

    // Monitor: compare at falling edges.
    always @(negedge clk) begin
        while (sbq.size() > 0 && sbq[0].at <= cyc) begin
            if (sbq[0].at < cyc) begin
                checks++;
                fails++;
                $display("FAIL %s missed slot at=%0d cyc=%0d", sbq[0].tag, sbq[0].at, cyc);
            end else begin
                chk(sbq[0].tag, drv_low, rst_line, sbq[0].low);
            end
            void'(sbq.pop_front());
        end
    end

    task automatic step();
        @(negedge clk);
        #1;
    endtask

    task automatic wait_until(input int c);
        while (cyc < c) step();
    endtask

    task automatic drain();
        while (sbq.size() > 0) step();
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired cyc=%0d", cyc);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin : stim
        int n;
        int m;
        // R1: reset state
        repeat (3) step();
        chk("R1 reset state", drv_low, rst_line, 1'b1);
        lock_i = 1'b0;
        #0.5;
        chk("R1 reset with lock low", drv_low, rst_line, 1'b1);
        lock_i = 1'b1;
        step();

        // R9: master reset release with lock held
        arst_n = 1'b1;
        n = cyc;
        push_exp(n + 1, 1'b1, "R9 just after reset release");
        push_exp(n + 1025, 1'b1, "R9 before release");
        push_exp(n + 1026, 1'b0, "R9 released (R8 pull-up)");
        drain();
        repeat (5) step();

        // R2/R3: long request
        req_n = 1'b0;
        #0.5;
        chk("R2 immediate low", drv_low, rst_line, 1'b1);
        n = cyc;
        push_exp(n + 10, 1'b1, "R2 held low");
        push_exp(n + 39, 1'b1, "R2 held low late");
        wait_until(n + 40);
        req_n = 1'b1;
        m = cyc;
        push_exp(m + 1026, 1'b1, "R3 before release");
        push_exp(m + 1027, 1'b0, "R3 released (R8)");
        drain();
        repeat (5) step();

        // R4: sub-period pulse
        req_n = 1'b0;
        #0.5;
        chk("R4 pulse seen", drv_low, rst_line, 1'b1);
        #0.5;
        req_n = 1'b1;
        n = cyc;
        push_exp(n + 1, 1'b1, "R4 captured");
        push_exp(n + 1026, 1'b1, "R4 before release");
        push_exp(n + 1027, 1'b0, "R4 released");
        drain();
        repeat (5) step();

        // R5: restart during active stretch
        req_n = 1'b0;
        #1;
        req_n = 1'b1;
        n = cyc;
        wait_until(n + 500);
        req_n = 1'b0;
        #1;
        req_n = 1'b1;
        m = cyc;
        push_exp(n + 1027, 1'b1, "R5 first stretch extended");
        push_exp(m + 1026, 1'b1, "R5 before restarted release");
        push_exp(m + 1027, 1'b0, "R5 restarted release");
        drain();
        repeat (5) step();

        // R6/R7: lock loss while idle
        lock_i = 1'b0;
        #0.3;
        chk("R6 immediate low", drv_low, rst_line, 1'b1);
        n = cyc;
        push_exp(n + 15, 1'b1, "R6 held while unlocked");
        wait_until(n + 20);
        lock_i = 1'b1;
        m = cyc;
        push_exp(m + 1025, 1'b1, "R7 before release");
        push_exp(m + 1026, 1'b0, "R7 released");
        drain();
        repeat (5) step();

        // R6/R7: lock loss during a stretch
        req_n = 1'b0;
        #1;
        req_n = 1'b1;
        n = cyc;
        wait_until(n + 300);
        lock_i = 1'b0;
        #0.3;
        chk("R6 lock loss in stretch", drv_low, rst_line, 1'b1);
        wait_until(n + 310);
        lock_i = 1'b1;
        m = cyc;
        push_exp(n + 1027, 1'b1, "R7 request stretch superseded");
        push_exp(m + 1025, 1'b1, "R7 before release after relock");
        push_exp(m + 1026, 1'b0, "R7 release after relock");
        drain();
        repeat (5) step();

        // R1/R9: master reset during a stretch
        req_n = 1'b0;
        #1;
        req_n = 1'b1;
        n = cyc;
        wait_until(n + 100);
        arst_n = 1'b0;
        #0.3;
        chk("R1 master reset mid stretch", drv_low, rst_line, 1'b1);
        wait_until(n + 105);
        arst_n = 1'b1;
        m = cyc;
        push_exp(m + 1025, 1'b1, "R9 before release");
        push_exp(m + 1026, 1'b0, "R9 release after reset");
        drain();
        repeat (3) step();

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule